// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register Access

This block gathers a configurable number of level-sensitive interrupt lines, from 2 to 64, into one combined interrupt request. Software controls each line through an enable bit and a mask bit. It reads a final status word that shows which lines are raised, enabled and not masked at the same time. Each register is split into a low word and a high word, with the high word 4 bytes above the low word. Software reaches all of them through a zero-wait-state APB slave port.

Flip-flops exist only for lines that the configuration provides. Register positions at or above the configured count read as zero. Software can therefore write all ones to the enable words, read them back, and work out how many lines the instance has. The input lines pass through one register stage. The status words are formed combinationally from that stage. The combined request is the OR of all status bits, delayed by one further register.

Top module: `irq_level_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every enable bit and mask bit is 0, both status words read 0, and `irq_o` is 0.
- R2: The enable register holds lines 0..31 at byte offset 0x00 (bit i = line i) and lines 32..63 at 0x04 (bit i-32 = line i). A write is visible on the next read. Positions for lines at or above NUM_SRC read 0 even after all ones are written, so with NUM_SRC=40 the high word reads 0x000000FF.
- R3: The mask register uses the same split at 0x08 (low) and 0x0C (high). Positions for absent lines also read 0.
- R4: The status words at 0x30 (low) and 0x34 (high) hold, for each line i, the value src_i[i] AND enable[i] AND NOT mask[i]. The input is sampled by one register stage, so a change driven before clock edge k appears in status after edge k.
- R5: A mask bit of 1 forces its status bit to 0, whatever the line and enable state. A mask bit of 0 lets the line through.
- R6: Status is level-sensitive. A status bit stays 1 for every cycle its line stays high, and returns to 0 one edge after the line drops, with nothing latched.
- R7: `irq_o` equals the OR of all status bits, registered once. It rises or falls on the edge after the status change.
- R8: Reads from any offset other than the six defined words return 0. Writes to them change no register.
- R9: `pready` is always 1 and `pslverr` is always 0.
- R10: A register is written only on the clock edge where `psel`, `penable` and `pwrite` are all 1. A setup phase that is not followed by an access phase changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero when not reading |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The collision of interest is a register write and a line change that land on the same clock edge. In that case a mask bit is cleared by an APB access while its line rises in that same access phase. The bench drives both on the same falling edge, so the mask flop and the input stage update together. It then judges the outcome in two ways. `irq_o` must still be low right after that edge and high one edge later, and the low status word read afterwards must show exactly that one bit.

// File: rtl/irqagg_pkg.sv
// Package irqagg_pkg
// Shared constants and the register-select type for the interrupt aggregator.
// Assumes byte addressing with 32-bit register words.
package irqagg_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned MAX_SRC = 64;

    localparam logic [7:0] OFS_ENABLE  = 8'h00;
    localparam logic [7:0] OFS_MASK    = 8'h08;
    localparam logic [7:0] OFS_STATUS  = 8'h30;
    localparam logic [7:0] OFS_HI_STEP = 8'h04;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_MK_LO,
        SEL_MK_HI,
        SEL_ST_LO,
        SEL_ST_HI
    } reg_sel_e;

endpackage

// File: rtl/irqagg_regs.sv
// Module irqagg_regs
// Enable and mask register bits. A flop is built only for line positions
// below NUM_SRC; absent positions are tied to zero.
// Assumes wr_en is already qualified to the APB access phase.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [MAX_SRC-1:0] enable_vec,
    output logic [MAX_SRC-1:0] mask_vec
);

    localparam logic [MAX_SRC-1:0] LIVE =
        (NUM_SRC >= MAX_SRC) ? {MAX_SRC{1'b1}} : ((64'd1 << NUM_SRC) - 64'd1);

    for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
        localparam int unsigned BITPOS = i % WORD_W;
        localparam reg_sel_e EN_SEL = (i < WORD_W) ? SEL_EN_LO : SEL_EN_HI;
        localparam reg_sel_e MK_SEL = (i < WORD_W) ? SEL_MK_LO : SEL_MK_HI;
        if (i < NUM_SRC) begin : g_live
            // Enable flop for line i: loads on an access-phase write to its word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    enable_vec[i] <= 1'b0;
                else if (wr_en && sel == EN_SEL)
                    enable_vec[i] <= wdata[BITPOS];
            end
            // Mask flop for line i: loads on an access-phase write to its word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mask_vec[i] <= 1'b0;
                else if (wr_en && sel == MK_SEL)
                    mask_vec[i] <= wdata[BITPOS];
            end
        end else begin : g_absent
            assign enable_vec[i] = 1'b0;
            assign mask_vec[i]   = 1'b0;
        end
    end

    AST_EN_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EN_LO) |=> (enable_vec[31:0] == ($past(wdata) & LIVE[31:0]))); // R2
    AST_EN_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EN_HI) |=> (enable_vec[63:32] == ($past(wdata) & LIVE[63:32]))); // R2
    AST_MK_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MK_LO) |=> (mask_vec[31:0] == ($past(wdata) & LIVE[31:0]))); // R3
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(enable_vec) && $stable(mask_vec))); // R10

endmodule

// File: rtl/irqagg_status.sv
// Module irqagg_status
// Registers the interrupt lines once, forms the final status from them and
// the enable/mask bits, and registers the OR of status as the combined request.
// Assumes the lines are level-sensitive and already synchronous to clk.
module irqagg_status
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [MAX_SRC-1:0] enable_vec,
    input  logic [MAX_SRC-1:0] mask_vec,
    output logic [MAX_SRC-1:0] status_vec,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] src_q;
    logic [MAX_SRC-1:0] src_wide;

    // Input stage: one register on every line.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    assign src_wide = MAX_SRC'(src_q);

    // Final status: raised, enabled and not masked.
    always_comb status_vec = src_wide & enable_vec & ~mask_vec;

    // Combined request: OR of status, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |status_vec;
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_vec) |=> irq_o); // R7
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status_vec) |=> !irq_o); // R7
    AST_STATUS_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec[NUM_SRC-1:0] & ~$past(src_i)) == '0)); // R6

endmodule

// File: rtl/irq_level_aggregator.sv
// Module irq_level_aggregator
// Top level: APB slave decode and read mux around the enable/mask register
// file and the status logic. Zero wait states, no error response.
// Assumes ADDR_W >= 8; addresses with any bit above bit 7 set decode to nothing.
module irq_level_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [WORD_W-1:0]  pwdata,
    output logic [WORD_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o
);

    localparam logic [MAX_SRC-1:0] LIVE =
        (NUM_SRC >= MAX_SRC) ? {MAX_SRC{1'b1}} : ((64'd1 << NUM_SRC) - 64'd1);

    reg_sel_e           sel;
    logic               wr_en;
    logic [MAX_SRC-1:0] enable_vec;
    logic [MAX_SRC-1:0] mask_vec;
    logic [MAX_SRC-1:0] status_vec;

    // Address decode onto the six defined words.
    always_comb begin
        sel = SEL_NONE;
        if ((paddr >> 8) == '0) begin
            case (paddr[7:0])
                OFS_ENABLE:               sel = SEL_EN_LO;
                OFS_ENABLE + OFS_HI_STEP: sel = SEL_EN_HI;
                OFS_MASK:                 sel = SEL_MK_LO;
                OFS_MASK + OFS_HI_STEP:   sel = SEL_MK_HI;
                OFS_STATUS:               sel = SEL_ST_LO;
                OFS_STATUS + OFS_HI_STEP: sel = SEL_ST_HI;
                default:                  sel = SEL_NONE;
            endcase
        end
    end

    assign wr_en   = psel && penable && pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    irqagg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel        (sel),
        .wdata      (pwdata),
        .enable_vec (enable_vec),
        .mask_vec   (mask_vec)
    );

    irqagg_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .enable_vec (enable_vec),
        .mask_vec   (mask_vec),
        .status_vec (status_vec),
        .irq_o      (irq_o)
    );

    // Read mux: selected word during a read, zero otherwise.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_EN_LO: prdata = enable_vec[31:0];
                SEL_EN_HI: prdata = enable_vec[63:32];
                SEL_MK_LO: prdata = mask_vec[31:0];
                SEL_MK_HI: prdata = mask_vec[63:32];
                SEL_ST_LO: prdata = status_vec[31:0];
                SEL_ST_HI: prdata = status_vec[63:32];
                default:   prdata = '0;
            endcase
        end
    end

    AST_MASK_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec & mask_vec) == '0)); // R5
    AST_ABSENT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && sel == SEL_EN_HI) |-> ((prdata & ~LIVE[63:32]) == '0)); // R2
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && sel == SEL_NONE) |-> (prdata == '0)); // R8

endmodule

// File: tb/irq_level_aggregator_test.sv
`timescale 1ns/1ps
module irq_level_aggregator_test;

    localparam int N = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [N-1:0] src = '0;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    irq_level_aggregator #(.NUM_SRC(N), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .src_i(src), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        apb_rd(8'h00, d); check("R1 en lo", d, 0);
        apb_rd(8'h04, d); check("R1 en hi", d, 0);
        apb_rd(8'h08, d); check("R1 mask lo", d, 0);
        apb_rd(8'h0C, d); check("R1 mask hi", d, 0);
        apb_rd(8'h30, d); check("R1 stat lo", d, 0);
        check("R1 irq", {31'd0, irq_o}, 0);
        check("R9 pready", {31'd0, pready}, 1);
        check("R9 pslverr", {31'd0, pslverr}, 0);
    endtask

    task automatic t_probe();
        logic [31:0] d;
        apb_wr(8'h00, 32'hFFFF_FFFF); apb_wr(8'h04, 32'hFFFF_FFFF);
        apb_rd(8'h00, d); check("R2 en lo", d, 32'hFFFF_FFFF);
        apb_rd(8'h04, d); check("R2 en hi probe", d, 32'h0000_00FF);
        apb_wr(8'h08, 32'hFFFF_FFFF); apb_wr(8'h0C, 32'hFFFF_FFFF);
        apb_rd(8'h08, d); check("R3 mask lo", d, 32'hFFFF_FFFF);
        apb_rd(8'h0C, d); check("R3 mask hi probe", d, 32'h0000_00FF);
        apb_wr(8'h08, 0); apb_wr(8'h0C, 0);
        apb_rd(8'h0C, d); check("R3 mask hi cleared", d, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk); src = 40'hA5_1234_5678;
        @(posedge clk); @(negedge clk);
        check("R7 irq not yet", {31'd0, irq_o}, 0);
        @(negedge clk);
        check("R7 irq risen", {31'd0, irq_o}, 1);
        apb_rd(8'h30, d); check("R4 stat lo", d, 32'h1234_5678);
        apb_rd(8'h34, d); check("R4 stat hi", d, 32'h0000_00A5);
        apb_wr(8'h00, 32'hFFFF_0000);
        apb_rd(8'h30, d); check("R4 enable gates", d, 32'h1234_0000);
        apb_wr(8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        apb_wr(8'h08, 32'h0000_FFFF);
        apb_rd(8'h30, d); check("R5 mask lo", d, 32'h1234_0000);
        apb_wr(8'h0C, 32'h0000_00F0);
        apb_rd(8'h34, d); check("R5 mask hi", d, 32'h0000_0005);
        apb_wr(8'h08, 32'hFFFF_FFFF);
        apb_wr(8'h0C, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 irq falls when all masked", {31'd0, irq_o}, 0);
        apb_wr(8'h08, 0); apb_wr(8'h0C, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); src = 40'h00_0000_0001;
        repeat (5) @(negedge clk);
        apb_rd(8'h30, d); check("R6 held level", d, 32'h1);
        apb_rd(8'h30, d); check("R6 still held", d, 32'h1);
        @(negedge clk); src = '0;
        @(posedge clk); @(negedge clk);
        apb_rd(8'h30, d); check("R6 released", d, 0);
        @(negedge clk);
        check("R6 irq released", {31'd0, irq_o}, 0);
    endtask

    task automatic t_undef();
        logic [31:0] d;
        apb_wr(8'h10, 32'h0000_0000);
        apb_wr(8'h38, 32'h0000_0000);
        apb_rd(8'h10, d); check("R8 undef read 0x10", d, 0);
        apb_rd(8'h38, d); check("R8 undef read 0x38", d, 0);
        apb_rd(8'h00, d); check("R8 en lo untouched", d, 32'hFFFF_FFFF);
        apb_rd(8'h08, d); check("R8 mask lo untouched", d, 0);
    endtask

    task automatic t_setup_only();
        logic [31:0] d;
        @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 0; penable = 0;
        @(negedge clk); psel = 0; pwrite = 0;
        apb_rd(8'h00, d); check("R10 setup only no write", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        apb_wr(8'h08, 32'h0000_0020);
        @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h08; pwdata = 0; penable = 0;
        @(negedge clk); penable = 1; src = 40'h00_0000_0020;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        check("R7 collide irq not yet", {31'd0, irq_o}, 0);
        @(negedge clk);
        check("R7 collide irq risen", {31'd0, irq_o}, 1);
        apb_rd(8'h30, d); check("R5 collide stat", d, 32'h0000_0020);
        check("R9 pready during run", {31'd0, pready}, 1);
    endtask

    initial begin
        #(4 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_probe();
        t_status();
        t_mask();
        t_level();
        t_undef();
        t_setup_only();
        t_collide();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule